// File: doc/BRIEF.md
# Error-Resilient K-Best Child Selector

This block carries out one tree-level expansion of a K-best sphere detector that works on real-valued 16-QAM, and it keeps working when the arithmetic that produced its inputs may have gone wrong. It takes K parent nodes. For each parent it receives an accumulated partial distance, an interference-cancelled target value and a diagonal channel coefficient. Every parent is expanded into its four amplitude children. The block returns the K children with the smallest accumulated distance, and for each one it also returns the symbol, the parent it came from, and a flag.

Every child is scored three times. The first score uses the target as received. The other two use the target with its top integer bit flipped, once upward and once downward. Only the lowest of the three scores is kept, so an erroneous branch never adds a child of its own. After this per-symbol minimum, the 4K candidates are ranked sequentially into a sorted list of K entries. The input and output each use a valid/ready handshake. The result appears a fixed number of cycles after the input is accepted, and it is held until it is taken.

Top module: `kbest_child_sel`

## Requirements
- R1: Each parent p yields exactly four candidates. Symbol index s selects the amplitude: 0 gives -3, 1 gives -1, 2 gives +1 and 3 gives +3. The candidates are ranked in the order p*4+s.
- R2: The target is a signed TW-bit value. The error weight is E = 2^(TW-2). The two erroneous targets are target+E and target-E, formed at TW+1 bits so they cannot wrap.
- R3: The branch metric is the smallest of (t' - coef*amplitude)^2 over the three targets t'. Each square saturates at 2^DW-1. The out_err bit is 1 only when an erroneous target gives a strictly smaller square than the error-free one.
- R4: The accumulated distance is the parent distance plus the branch metric, and it saturates at 2^DW-1 instead of wrapping.
- R5: Output entry 0 is the best. Entries are ordered by ascending distance. Equal distances are ordered by lower parent index, then by lower symbol index.
- R6: The K outputs are exactly the K smallest of the 4K candidates under the ordering of R5.
- R7: in_ready is high only when the block is idle. Input presented while a job is running or a result is waiting has no effect on that result.
- R8: out_valid rises exactly 4K+2 clock cycles after the input handshake.
- R9: While out_valid is high and out_ready is low, all output fields hold their values. One cycle after the output handshake, out_valid is low and in_ready is high.
- R10: After reset, in_ready is 1 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input job is presented |
| in_ready | output | 1 | Block is idle and will accept a job |
| in_pdist | input | K*DW | Parent accumulated distances, unsigned, parent p at bits [p*DW +: DW] |
| in_target | input | K*TW | Parent targets, two's complement |
| in_coef | input | K*CW | Parent diagonal coefficients, unsigned, in the same LSB scale as the target |
| out_valid | output | 1 | Sorted survivor list is available |
| out_ready | input | 1 | Consumer takes the list |
| out_dist | output | K*DW | Survivor accumulated distances, entry 0 is the best |
| out_sym | output | K*2 | Survivor symbol indices |
| out_parent | output | K*PW | Survivor parent indices |
| out_err | output | K | An erroneous variant gave the survivor's metric |

## Verification
The hardest situations to reach are exact ties and saturation. Ties must be resolved by parent and then symbol index, and saturation must clamp both the square and the sum. Random targets rarely produce either. Directed jobs therefore set every target and coefficient to zero so that all 4K distances are equal, set parent distances near the top of the range, and pick a target near the integer MSB with a coefficient such that a flipped target lands closer. These are mixed with seeded random jobs, some of which push new input while busy or hold off out_ready.

// File: rtl/kb_pkg.sv
package kb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PREP = 3'd1,
    ST_RUN  = 3'd2,
    ST_FIN  = 3'd3,
    ST_HOLD = 3'd4
  } kb_state_e;

  // amplitude for a 2-bit symbol index: 0..3 -> -3,-1,+1,+3
  function automatic logic signed [3:0] sym_level(input logic [1:0] s);
    return $signed({1'b0, s, 1'b0}) - 4'sd3;
  endfunction
endpackage

// File: rtl/kb_branch_metric.sv
module kb_branch_metric #(
  parameter int TW = 8,
  parameter int CW = 6,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        pdist,
  input  logic signed [TW-1:0] target,
  input  logic [CW-1:0]        coef,
  output logic [4*DW-1:0]      acc_flat,
  output logic [3:0]           err
);
  localparam int EW  = TW + 1;
  localparam int MW  = CW + 3;
  localparam int XW  = ((EW > MW) ? EW : MW) + 1;
  localparam int SQW = 2 * XW;
  localparam int LW  = (SQW > DW) ? SQW : DW;
  localparam logic [DW-1:0] DMAX = '1;

  logic signed [EW-1:0] t_free, t_up, t_dn;
  always_comb begin
    t_free = EW'(target);
    t_up   = t_free + EW'(signed'(1 << (TW - 2)));
    t_dn   = t_free - EW'(signed'(1 << (TW - 2)));
  end

  function automatic logic [DW-1:0] sat_sq(input logic signed [XW-1:0] d);
    logic signed [SQW-1:0] sq;
    logic [LW-1:0] sqz;
    sq  = SQW'(d) * SQW'(d);
    sqz = LW'($unsigned(sq));
    return (sqz > LW'(DMAX)) ? DMAX : sqz[DW-1:0];
  endfunction

  for (genvar s = 0; s < 4; s++) begin : g_sym
    logic signed [MW-1:0] cs;
    logic [DW-1:0] m_free, m_up, m_dn, m_err, m_sel;
    logic          use_err;
    logic [DW:0]   sum;
    logic [DW-1:0] acc;

    always_comb begin
      cs      = $signed({3'b000, coef}) * MW'(kb_pkg::sym_level(2'(s)));
      m_free  = sat_sq(XW'(t_free) - XW'(cs));
      m_up    = sat_sq(XW'(t_up) - XW'(cs));
      m_dn    = sat_sq(XW'(t_dn) - XW'(cs));
      m_err   = (m_up <= m_dn) ? m_up : m_dn;
      use_err = m_err < m_free;
      m_sel   = use_err ? m_err : m_free;
      sum     = {1'b0, pdist} + {1'b0, m_sel};
      acc     = sum[DW] ? DMAX : sum[DW-1:0];
    end

    assign acc_flat[s*DW +: DW] = acc;
    assign err[s] = use_err;

    a_r3_min_of_three: assert property (@(posedge clk) disable iff (!rst_n)
      (m_sel <= m_free) && (m_sel <= m_up) && (m_sel <= m_dn));
    a_r3_flag_strict: assert property (@(posedge clk) disable iff (!rst_n)
      use_err |-> (m_sel < m_free));
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (acc >= pdist) && (acc >= m_sel));
  end
endmodule

// File: rtl/kb_sorter.sv
module kb_sorter #(
  parameter int K  = 4,
  parameter int DW = 16,
  parameter int PW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            ins,
  input  logic [DW-1:0]   c_dist,
  input  logic [PW-1:0]   c_par,
  input  logic [1:0]      c_sym,
  input  logic            c_err,
  output logic [K*DW-1:0] o_dist,
  output logic [K*PW-1:0] o_par,
  output logic [K*2-1:0]  o_sym,
  output logic [K-1:0]    o_err
);
  typedef struct packed {
    logic          v;
    logic [DW-1:0] d;
    logic [PW-1:0] p;
    logic [1:0]    s;
    logic          e;
  } ent_t;

  ent_t lst_q [K];
  ent_t lst_d [K];
  ent_t cand;
  logic [K-1:0] beat;

  assign cand = '{v: 1'b1, d: c_dist, p: c_par, s: c_sym, e: c_err};

  for (genvar i = 0; i < K; i++) begin : g_cmp
    assign beat[i] = !lst_q[i].v ||
                     ({c_dist, c_par, c_sym} < {lst_q[i].d, lst_q[i].p, lst_q[i].s});
    assign o_dist[i*DW +: DW] = lst_q[i].d;
    assign o_par[i*PW +: PW]  = lst_q[i].p;
    assign o_sym[i*2 +: 2]    = lst_q[i].s;
    assign o_err[i]           = lst_q[i].e;
  end

  always_comb begin
    for (int i = 0; i < K; i++) lst_d[i] = lst_q[i];
    if (clr) begin
      for (int i = 0; i < K; i++) lst_d[i] = '0;
    end else if (ins) begin
      if (beat[0]) lst_d[0] = cand;
      for (int i = 1; i < K; i++) begin
        if (beat[i - 1])  lst_d[i] = lst_q[i - 1];
        else if (beat[i]) lst_d[i] = cand;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < K; i++) lst_q[i] <= '0;
    end else if (clr || ins) begin
      for (int i = 0; i < K; i++) lst_q[i] <= lst_d[i];
    end
  end

  for (genvar i = 1; i < K; i++) begin : g_chk
    a_r5_ordered: assert property (@(posedge clk) disable iff (!rst_n)
      lst_q[i].v |-> (lst_q[i-1].v &&
        ({lst_q[i-1].d, lst_q[i-1].p, lst_q[i-1].s} < {lst_q[i].d, lst_q[i].p, lst_q[i].s})));
  end
endmodule

// File: rtl/kbest_child_sel.sv
module kbest_child_sel #(
  parameter int K  = 4,
  parameter int TW = 8,
  parameter int CW = 6,
  parameter int DW = 16,
  localparam int PW = (K > 1) ? $clog2(K) : 1,
  localparam int NC = 4 * K,
  localparam int NW = $clog2(NC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [K*DW-1:0] in_pdist,
  input  logic [K*TW-1:0] in_target,
  input  logic [K*CW-1:0] in_coef,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [K*DW-1:0] out_dist,
  output logic [K*2-1:0]  out_sym,
  output logic [K*PW-1:0] out_parent,
  output logic [K-1:0]    out_err
);
  import kb_pkg::*;

  kb_state_e state_q, state_d;
  logic [NW-1:0] cnt_q, cnt_d;
  logic          accept, take;

  logic [K*DW-1:0] pdist_q;
  logic [K*TW-1:0] target_q;
  logic [K*CW-1:0] coef_q;
  logic [NC*DW-1:0] acc_all;
  logic [NC-1:0]    err_all;
  logic [NC*DW-1:0] cd_q;
  logic [NC-1:0]    ce_q;

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
  assign accept    = in_valid && in_ready;
  assign take      = out_valid && out_ready;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_PREP;
      ST_PREP: begin state_d = ST_RUN; cnt_d = '0; end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == NW'(NC - 1)) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_HOLD;
      ST_HOLD: if (take) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdist_q  <= '0;
      target_q <= '0;
      coef_q   <= '0;
    end else if (accept) begin
      pdist_q  <= in_pdist;
      target_q <= in_target;
      coef_q   <= in_coef;
    end
  end

  for (genvar p = 0; p < K; p++) begin : g_par
    kb_branch_metric #(.TW(TW), .CW(CW), .DW(DW)) u_bm (
      .clk      (clk),
      .rst_n    (rst_n),
      .pdist    (pdist_q[p*DW +: DW]),
      .target   (target_q[p*TW +: TW]),
      .coef     (coef_q[p*CW +: CW]),
      .acc_flat (acc_all[p*4*DW +: 4*DW]),
      .err      (err_all[p*4 +: 4])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cd_q <= '0;
      ce_q <= '0;
    end else if (state_q == ST_PREP) begin
      cd_q <= acc_all;
      ce_q <= err_all;
    end
  end

  kb_sorter #(.K(K), .DW(DW), .PW(PW)) u_sort (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (state_q == ST_PREP),
    .ins    (state_q == ST_RUN),
    .c_dist (cd_q[cnt_q*DW +: DW]),
    .c_par  (PW'(cnt_q >> 2)),
    .c_sym  (cnt_q[1:0]),
    .c_err  (ce_q[cnt_q]),
    .o_dist (out_dist),
    .o_par  (out_parent),
    .o_sym  (out_sym),
    .o_err  (out_err)
  );

  // cycles since the last accepted job, for the latency check
  logic [NW+1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else if (accept) lat_q <= '0;
    else if (!in_ready && !out_valid) lat_q <= lat_q + 1'b1;
  end

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_q == (NW+2)'(NC + 2)));
  a_r7_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || state_q != ST_IDLE) |-> !in_ready);
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dist) &&
      $stable(out_sym) && $stable(out_parent) && $stable(out_err)));
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));
endmodule

// File: tb/kbest_child_sel_tb.sv
module kbest_child_sel_tb;
  localparam int K  = 4;
  localparam int TW = 8;
  localparam int CW = 6;
  localparam int DW = 16;
  localparam int PW = 2;
  localparam longint DMAX = (64'd1 << DW) - 1;
  localparam longint EWT  = 64'd1 << (TW - 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [K*DW-1:0] in_pdist = '0;
  logic [K*TW-1:0] in_target = '0;
  logic [K*CW-1:0] in_coef = '0;
  logic [K*DW-1:0] out_dist;
  logic [K*2-1:0]  out_sym;
  logic [K*PW-1:0] out_parent;
  logic [K-1:0]    out_err;

  always #4 clk = ~clk;

  kbest_child_sel #(.K(K), .TW(TW), .CW(CW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pdist(in_pdist), .in_target(in_target), .in_coef(in_coef),
    .out_valid(out_valid), .out_ready(out_ready), .out_dist(out_dist),
    .out_sym(out_sym), .out_parent(out_parent), .out_err(out_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  longint pd[K];
  longint tg[K];
  longint cf[K];
  longint ed[K];
  int ep[K];
  int es[K];
  int ee[K];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sq_sat(input longint d);
    longint s = d * d;
    return (s > DMAX) ? DMAX : s;
  endfunction

  // reference model built from the requirements
  task automatic model();
    longint cd[4*K];
    int     ce[4*K];
    bit     used[4*K];
    for (int p = 0; p < K; p++) begin
      for (int s = 0; s < 4; s++) begin
        longint amp = 2 * s - 3;
        longint m0  = sq_sat(tg[p] - cf[p] * amp);
        longint mu  = sq_sat(tg[p] + EWT - cf[p] * amp);
        longint md  = sq_sat(tg[p] - EWT - cf[p] * amp);
        longint me  = (mu < md) ? mu : md;
        longint m   = (me < m0) ? me : m0;
        longint a   = pd[p] + m;
        cd[p*4+s] = (a > DMAX) ? DMAX : a;
        ce[p*4+s] = (me < m0) ? 1 : 0;
        used[p*4+s] = 1'b0;
      end
    end
    for (int k = 0; k < K; k++) begin
      int b = -1;
      for (int c = 0; c < 4*K; c++) begin
        if (!used[c] && (b < 0 || cd[c] < cd[b])) b = c;
      end
      used[b] = 1'b1;
      ed[k] = cd[b]; ep[k] = b / 4; es[k] = b % 4; ee[k] = ce[b];
    end
  endtask

  task automatic drive_vals();
    for (int p = 0; p < K; p++) begin
      in_pdist[p*DW +: DW]  = DW'(pd[p]);
      in_target[p*TW +: TW] = TW'(tg[p]);
      in_coef[p*CW +: CW]   = CW'(cf[p]);
    end
  endtask

  task automatic run_job(input bit poke_busy, input int hold_cycles);
    int cyc;
    model();
    @(negedge clk);
    drive_vals();
    in_valid = 1'b1;
    chk(in_ready == 1'b1, "R7 idle ready", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    cyc = 0;
    chk(in_ready == 1'b0, "R7 busy not ready", in_ready, 0);
    if (poke_busy) begin
      for (int p = 0; p < K; p++) begin
        in_pdist[p*DW +: DW] = DW'($urandom);
        in_target[p*TW +: TW] = TW'($urandom);
        in_coef[p*CW +: CW] = CW'($urandom);
      end
    end else begin
      in_valid = 1'b0;
    end
    while (!out_valid && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == 4*K + 2, "R8 latency", cyc, 4*K + 2);
    for (int k = 0; k < K; k++) begin
      bit ok = (out_dist[k*DW +: DW] == DW'(ed[k])) &&
               (out_parent[k*PW +: PW] == PW'(ep[k])) &&
               (out_sym[k*2 +: 2] == 2'(es[k])) && (out_err[k] == ee[k][0]);
      chk(ok, "R1 R3 R4 R5 R6 entry",
          {out_dist[k*DW +: DW], 4'(out_parent[k*PW +: PW]), 4'(out_sym[k*2 +: 2]), 4'(out_err[k])},
          {DW'(ed[k]), 4'(ep[k]), 4'(es[k]), 4'(ee[k])});
    end
    for (int h = 0; h < hold_cycles; h++) begin
      @(negedge clk);
      chk(out_valid && out_dist[DW-1:0] == DW'(ed[0]) && out_sym[1:0] == 2'(es[0]),
          "R9 hold", out_dist[DW-1:0], ed[0]);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R9 release", {out_valid, in_ready}, 2'b01);
  endtask

  initial begin
    #1_600_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R10 reset", {in_ready, out_valid}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R10 after reset", {in_ready, out_valid}, 2'b10);

    // R5 ties: all distances equal, order by parent then symbol
    for (int p = 0; p < K; p++) begin pd[p] = 100; tg[p] = 0; cf[p] = 0; end
    run_job(1'b0, 0);

    // R4 saturation at the top of the distance range
    for (int p = 0; p < K; p++) begin pd[p] = DMAX - p; tg[p] = 127; cf[p] = 63; end
    run_job(1'b0, 2);

    // R2 R3 flipped target wins: target near integer MSB, small amplitude product
    for (int p = 0; p < K; p++) begin pd[p] = 10 * p; tg[p] = 100 - 3 * p; cf[p] = 10; end
    run_job(1'b0, 0);

    // R2 negative extreme target, downward flip at the extra bit
    for (int p = 0; p < K; p++) begin pd[p] = 0; tg[p] = -128 + p; cf[p] = 63 - p; end
    run_job(1'b0, 1);

    // R7 input pushed while busy must not disturb the result
    for (int p = 0; p < K; p++) begin pd[p] = $urandom_range(0, 500); tg[p] = $urandom_range(0, 255) - 128; cf[p] = $urandom_range(0, 63); end
    run_job(1'b1, 1);

    // seeded random jobs, R6 among others
    for (int j = 0; j < 40; j++) begin
      for (int p = 0; p < K; p++) begin
        pd[p] = (j % 5 == 0) ? DMAX - $urandom_range(0, 3000) : $urandom_range(0, 4000);
        tg[p] = $urandom_range(0, 255) - 128;
        cf[p] = $urandom_range(0, 63);
      end
      run_job(j % 7 == 3, j % 3);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule